// File: doc/BRIEF.md
# PHY Rate Change Responder

This block plays the PHY side of one lane during a line-rate change on a PIPE-style interface. A link controller moves the lane into standby, idles its transmitter and writes a new rate code. The responder then puts the receive path into reset and waits for the rate code to settle. It offers a clock-change grant and waits for the controller's acknowledge. It answers with a one-cycle status pulse, and in that same cycle it withdraws the grant. After the controller drops the acknowledge and leaves standby, the responder signals CDR lock and then takes the receive path out of reset. Each phase lasts a number of cycles set by a parameter.

Two lane-level helpers sit next to the handshake. Transmit data is forced to zero while transmit electrical idle is asserted. A qualified receive-valid output combines the receive reset status with both receive data-valid strobes. The block has no real clock generation and no serial datapath. It is meant as a synthesizable stand-in when testing a rate-change controller.

Top module: `phy_rate_resp`

## Requirements
- R1: After reset the lane is in its steady state: `rx_rst_n_o` is 1, `cdr_lock_o` is 1, `clkchg_ok_o` is 0 and `phystatus_o` is 0.
- R2: When the steady state samples `rate_i` at a clock edge and it differs from its value at the previous edge, `rx_rst_n_o` and `cdr_lock_o` go to 0 from that edge onward.
- R3: `clkchg_ok_o` rises SETTLE_CYC edges after the last edge that saw `rate_i` change. A further change of the rate restarts this count. `rx_rst_n_o` is 0 whenever the grant rises.
- R4: The edge that first samples `clkchg_ack_i` high while the grant is up is edge A. At edge A+ACK_CYC, `phystatus_o` rises and `clkchg_ok_o` falls together. `phystatus_o` is high for exactly one cycle.
- R5: After the status pulse, the responder waits until `clkchg_ack_i` and `standby_i` are both sampled low, at edge W. `cdr_lock_o` rises at edge W+LOCK_CYC and `rx_rst_n_o` rises REL_CYC edges after that. Holding either input high delays both.
- R6: `tx_data_o` is all zeros while `tx_idle_i` is 1 and equals `tx_data_i` while it is 0. The controller must hold `tx_valid_i` at 1 in any cycle where `tx_idle_i` toggles.
- R7: `rx_valid_o` is 1 only when `rx_rst_n_o`, `rx_dv0_i` and `rx_dv1_i` are all 1.
- R8: Outside a rate change, `clkchg_ok_o` and `phystatus_o` stay 0. A `clkchg_ack_i` pulse in the steady state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | Controller holds the lane in standby |
| rate_i | input | RATE_W | Requested rate code |
| tx_idle_i | input | 1 | Transmit electrical idle |
| tx_valid_i | input | 1 | Transmit data valid |
| tx_data_i | input | DATA_W | Transmit data from the controller |
| clkchg_ack_i | input | 1 | Controller acknowledges the clock change |
| rx_dv0_i | input | 1 | Receive data-valid strobe 0 |
| rx_dv1_i | input | 1 | Receive data-valid strobe 1 |
| tx_data_o | output | DATA_W | Transmit data after idle masking |
| clkchg_ok_o | output | 1 | Clock-change grant |
| phystatus_o | output | 1 | One-cycle completion status |
| cdr_lock_o | output | 1 | Receive CDR locked to data |
| rx_rst_n_o | output | 1 | Receive path out of reset (active low reset) |
| rx_valid_o | output | 1 | Qualified receive valid |

## Verification
The hardest case to reach from the ports is a second rate change that lands inside the settle window. The grant time must then be measured from the second change, not the first. The stimulus writes a second code two cycles after the first, well inside the settle count. A second hard case is a controller that drops the acknowledge but stays in standby for several more cycles. The stimulus delays the standby release, and the expected lock and release cycles are computed from the cycle standby actually falls. A scoreboard checks the exact cycle of every output edge, so a change that is early or late by one cycle is reported.

// File: rtl/phy_rate_resp.sv
module phy_rate_resp #(
  parameter int DATA_W     = 32,
  parameter int RATE_W     = 3,
  parameter int SETTLE_CYC = 3,
  parameter int ACK_CYC    = 2,
  parameter int LOCK_CYC   = 6,
  parameter int REL_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              tx_idle_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              clkchg_ack_i,
  input  logic              rx_dv0_i,
  input  logic              rx_dv1_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              clkchg_ok_o,
  output logic              phystatus_o,
  output logic              cdr_lock_o,
  output logic              rx_rst_n_o,
  output logic              rx_valid_o
);

  localparam int MAX_AB = (SETTLE_CYC > ACK_CYC) ? SETTLE_CYC : ACK_CYC;
  localparam int MAX_CD = (LOCK_CYC > REL_CYC) ? LOCK_CYC : REL_CYC;
  localparam int MAX_D  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAX_D + 1);

  typedef enum logic [2:0] {
    S_RUN, S_SETTLE, S_GRANT, S_ACKD, S_PST, S_WSB, S_LOCK, S_REL
  } st_t;

  st_t               state;
  logic [CW-1:0]     cnt, lim;
  logic [RATE_W-1:0] rate_q;
  logic              rate_chg, hit;

  assign rate_chg = rate_i != rate_q;
  assign hit      = cnt == lim;

  always_comb begin
    case (state)
      S_SETTLE: lim = CW'(SETTLE_CYC - 1);
      S_ACKD:   lim = CW'(ACK_CYC - 1);
      S_LOCK:   lim = CW'(LOCK_CYC - 1);
      S_REL:    lim = CW'(REL_CYC - 1);
      default:  lim = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_RUN;
      cnt    <= '0;
      rate_q <= '0;
    end else begin
      rate_q <= rate_i;
      case (state)
        S_RUN: if (rate_chg) begin
          state <= S_SETTLE;
          cnt   <= '0;
        end
        S_SETTLE: begin
          if (rate_chg) cnt <= '0;
          else if (hit) begin
            state <= S_GRANT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_GRANT: if (clkchg_ack_i) begin
          state <= S_ACKD;
          cnt   <= '0;
        end
        S_ACKD: begin
          if (hit) begin
            state <= S_PST;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PST: state <= S_WSB;
        S_WSB: if (!clkchg_ack_i && !standby_i) begin
          state <= S_LOCK;
          cnt   <= '0;
        end
        S_LOCK: begin
          if (hit) begin
            state <= S_REL;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_REL: begin
          if (hit) begin
            state <= S_RUN;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign clkchg_ok_o = (state == S_GRANT) || (state == S_ACKD);
  assign phystatus_o = state == S_PST;
  assign cdr_lock_o  = (state == S_RUN) || (state == S_REL);
  assign rx_rst_n_o  = state == S_RUN;
  assign rx_valid_o  = rx_rst_n_o & rx_dv0_i & rx_dv1_i;
  assign tx_data_o   = tx_idle_i ? '0 : tx_data_i;

  // R6
  idle_toggle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle_i != $past(tx_idle_i)) |-> tx_valid_i);

  // R3
  grant_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkchg_ok_o) |-> !rx_rst_n_o);

  // R4
  status_with_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkchg_ok_o) |-> phystatus_o);

  // R4
  status_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phystatus_o |-> $past(clkchg_ok_o));

  // R4
  status_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phystatus_o |=> !phystatus_o);

  // R5
  release_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rst_n_o) |-> $past(cdr_lock_o));

  // R8
  quiet_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_n_o |-> (!clkchg_ok_o && !phystatus_o));

endmodule

// File: tb/phy_rate_resp_tb_top.sv
module phy_rate_resp_tb_top;
  localparam int DW = 32, RW = 3, SET = 3, ACKC = 2, LCK = 6, REL = 3;
  localparam int K_RSTLO = 0, K_LOCKLO = 1, K_OKHI = 2, K_OKLO = 3,
                 K_PSHI = 4, K_PSLO = 5, K_LOCKHI = 6, K_RSTHI = 7;

  logic clk = 0, rst_n = 0, standby = 0, tx_idle = 0, tx_valid = 1, ack = 0;
  logic dv0 = 0, dv1 = 0;
  logic [RW-1:0] rate = '0;
  logic [DW-1:0] txd = '0;
  logic [DW-1:0] txd_o;
  logic ok_o, ps_o, lock_o, rrst_o, rxv_o;

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 0;
  logic p_ok, p_ps, p_lock, p_rst;

  typedef struct { int kind; int cyc; string req; } ev_t;
  ev_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_rate_resp #(.DATA_W(DW), .RATE_W(RW), .SETTLE_CYC(SET), .ACK_CYC(ACKC),
                  .LOCK_CYC(LCK), .REL_CYC(REL)) dut_i (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .rate_i(rate),
    .tx_idle_i(tx_idle), .tx_valid_i(tx_valid), .tx_data_i(txd),
    .clkchg_ack_i(ack), .rx_dv0_i(dv0), .rx_dv1_i(dv1),
    .tx_data_o(txd_o), .clkchg_ok_o(ok_o), .phystatus_o(ps_o),
    .cdr_lock_o(lock_o), .rx_rst_n_o(rrst_o), .rx_valid_o(rxv_o));

  task automatic chk(bit good, string req, string what, longint act, longint expv);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int k, int c, string r);
    ev_t e;
    e.kind = k; e.cyc = c; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic got(int k);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R8", "unexpected output edge kind", k, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == k, e.req, "edge kind", k, e.kind);
      chk(e.cyc == cyc, e.req, "edge cycle", cyc, e.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (p_rst && !rrst_o)  got(K_RSTLO);
      if (p_lock && !lock_o) got(K_LOCKLO);
      if (!p_ok && ok_o)     got(K_OKHI);
      if (p_ok && !ok_o)     got(K_OKLO);
      if (!p_ps && ps_o)     got(K_PSHI);
      if (p_ps && !ps_o)     got(K_PSLO);
      if (!p_lock && lock_o) got(K_LOCKHI);
      if (!p_rst && rrst_o)  got(K_RSTHI);
    end
    p_ok = ok_o; p_ps = ps_o; p_lock = lock_o; p_rst = rrst_o;
  end

  task automatic do_change(logic [RW-1:0] ra, bit restart, logic [RW-1:0] rb, int sb_lag);
    int c, a, s;
    @(negedge clk);
    standby = 1; tx_valid = 1; tx_idle = 1;
    @(negedge clk);
    tx_valid = 0;
    rate = ra; c = cyc;
    push(K_RSTLO, c + 1, "R2"); push(K_LOCKLO, c + 1, "R2");
    @(negedge clk);
    dv0 = 1; dv1 = 1; #1;
    chk(rxv_o == 0, "R7", "rx_valid during rx reset", rxv_o, 0);
    @(negedge clk);
    if (restart) begin
      rate = rb; c = cyc;
    end
    push(K_OKHI, c + 1 + SET, "R3");
    while (!ok_o) @(negedge clk);
    chk(rrst_o == 0, "R3", "rx reset status at grant", rrst_o, 0);
    ack = 1; a = cyc;
    push(K_OKLO, a + 1 + ACKC, "R4"); push(K_PSHI, a + 1 + ACKC, "R4");
    push(K_PSLO, a + 2 + ACKC, "R4");
    repeat (ACKC + 3) @(negedge clk);
    ack = 0;
    if (sb_lag > 0) begin
      repeat (sb_lag) @(negedge clk);
      chk(lock_o == 0, "R5", "cdr lock while standby held", lock_o, 0);
      chk(rrst_o == 0, "R5", "rx reset while standby held", rrst_o, 0);
    end
    standby = 0; s = cyc;
    push(K_LOCKHI, s + 1 + LCK, "R5"); push(K_RSTHI, s + 1 + LCK + REL, "R5");
    repeat (LCK + REL + 4) @(negedge clk);
    tx_valid = 1;
    @(negedge clk);
    tx_idle = 0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rrst_o == 1, "R1", "rx_rst_n after reset", rrst_o, 1);
    chk(lock_o == 1, "R1", "cdr_lock after reset", lock_o, 1);
    chk(ok_o == 0, "R1", "clkchg_ok after reset", ok_o, 0);
    chk(ps_o == 0, "R1", "phystatus after reset", ps_o, 0);
    mon_en = 1;

    // R6 masking
    txd = 32'hA5C3_0F1E; tx_idle = 0; #1;
    chk(txd_o == 32'hA5C3_0F1E, "R6", "tx data passes when active", txd_o, 32'hA5C3_0F1E);
    @(negedge clk); tx_idle = 1; #1;
    chk(txd_o == 0, "R6", "tx data masked in idle", txd_o, 0);
    txd = 32'h1234_5678; #1;
    chk(txd_o == 0, "R6", "new tx data still masked", txd_o, 0);
    @(negedge clk); tx_idle = 0; #1;
    chk(txd_o == 32'h1234_5678, "R6", "tx data passes after idle", txd_o, 32'h1234_5678);

    // R7 qualified valid
    for (int v = 0; v < 4; v++) begin
      dv0 = v[0]; dv1 = v[1]; #1;
      chk(rxv_o == (v == 3), "R7", "rx_valid in steady state", rxv_o, (v == 3));
    end

    // R8 ack pulse in steady state
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    repeat (4) @(negedge clk);
    chk(ok_o == 0, "R8", "grant after stray ack", ok_o, 0);
    chk(ps_o == 0, "R8", "status after stray ack", ps_o, 0);
    chk(rrst_o == 1, "R8", "rx reset after stray ack", rrst_o, 1);

    do_change(3'd4, 1'b0, 3'd0, 0);
    do_change(3'd1, 1'b1, 3'd2, 0);
    do_change(3'd3, 1'b0, 3'd0, 5);

    dv0 = 1; dv1 = 1; #1;
    chk(rxv_o == 1, "R7", "rx_valid after release", rxv_o, 1);
    chk(exp_q.size() == 0, "R5", "pending expected edges", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule